// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion

This block drives the high-side and low-side switches of a half bridge from one up-counting timer. The count advances once per counter-clock tick, which arrives as a one-cycle enable, and returns to zero after it reaches a programmable top value. A duty threshold splits each period into two phases. The leading output `pwm_hi` is high in the first phase and the trailing output `pwm_lo` is high in the second.

When dead-time insertion is on, each output's rising edge is held back by a programmable number of ticks, counted from the start of its own phase. The falling edge is not delayed. The low-side output therefore rises a dead time after the high side drops at the duty match. The high side rises a dead time after the low side drops at the reload. The two outputs are never high together.

All three outputs come from registers and change on the same clock edge as the count. There is no data stream in or out, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `pwm_dt_gen`

## Requirements
- R1: On a clock with `cnt_tick` high, the count wraps to 0 if it is greater than or equal to `top_val`; otherwise it goes up by 1. A period is therefore `top_val`+1 ticks, and the count is 0 after reset.
- R2: `wrap_pulse` is high for exactly the one clock that follows each wrapping tick and is low at all other times.
- R3: With insertion off, `pwm_hi` is 1 exactly while the count is below `duty_val`, so it goes low on the clock where the count reaches `duty_val`.
- R4: With insertion off (`dt_on`=0), `pwm_lo` is the exact inverse of `pwm_hi` on every clock, with no delay.
- R5: With insertion on, `pwm_hi` is 1 exactly while `dt_ticks` <= count < `duty_val`. Its rise is delayed `dt_ticks` ticks after the wrap.
- R6: With insertion on, `pwm_lo` is 1 exactly while count >= `duty_val` and count - `duty_val` >= `dt_ticks`. It rises `dt_ticks` ticks after the duty match and falls on the wrapping tick.
- R7: `pwm_hi` and `pwm_lo` are never both 1.
- R8: `dt_ticks`=0 with insertion on gives the same outputs as insertion off.
- R9: If `dt_ticks` is at least as long as a phase, the delayed output stays 0 for the whole of that phase.
- R10: On clocks with `cnt_tick` low, the count holds. The outputs then change only if `duty_val`, `dt_ticks` or `dt_on` change.
- R11: While `rst_n` is low, `pwm_hi`, `pwm_lo` and `wrap_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Counter-clock enable, one tick per cycle high |
| duty_val | input | CNT_W | Duty threshold (end of leading phase) |
| top_val | input | CNT_W | Top count before wrap |
| dt_ticks | input | DT_W | Dead time in counter ticks |
| dt_on | input | 1 | Dead-time insertion enable |
| pwm_hi | output | 1 | Leading-phase output |
| pwm_lo | output | 1 | Trailing-phase output |
| wrap_pulse | output | 1 | One-clock pulse after each wrap |

## Verification
Directed runs cover the main cases:
- Insertion off (R3, R4) and a zero dead time (R8). Comparing these separates a real delay path from a plain inverter.
- A small dead time (R5, R6). This shows the delay is anchored to each phase start, not to the wrap alone.
- A dead time longer than either phase (R9). Here a wrong comparison would show as a glitch.
- Runs with the tick held low (R10), and a counted run of wrap pulses against the top value (R1, R2).

Seeded random runs then vary the duty, top, dead time, enable and tick density together. This includes a duty of zero and a duty above the top value, where one phase is empty.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_DT_W  = 7;

  // which half of the period a channel owns
  typedef enum logic {
    PH_LEAD  = 1'b0,
    PH_TRAIL = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter #(
  parameter int unsigned CNT_W = pwm_dt_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             wrap_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  // >= so that lowering top below the current count still wraps
  assign wrap   = tick && (cnt_q >= top_val);
  assign cnt_nx = !tick ? cnt_q : (wrap ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      wrap_q <= wrap;
    end
  end
endmodule

// File: rtl/pwm_dt_phase.sv
module pwm_dt_phase #(
  parameter int unsigned        CNT_W = pwm_dt_pkg::DEF_CNT_W,
  parameter int unsigned        DT_W  = pwm_dt_pkg::DEF_DT_W,
  parameter pwm_dt_pkg::phase_e PHASE = pwm_dt_pkg::PH_LEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] duty_val,
  input  logic [DT_W-1:0]  dt_ticks,
  input  logic             dt_on,
  output logic             pwm_q
);
  localparam int unsigned PAD_W = CNT_W - DT_W;

  logic             in_phase;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] dt_ext;
  logic             gate_open;

  assign dt_ext = {{PAD_W{1'b0}}, dt_ticks};

  // elapsed = ticks since this channel's phase began
  generate
    if (PHASE == pwm_dt_pkg::PH_LEAD) begin : g_lead
      assign in_phase = cnt_nx < duty_val;
      assign elapsed  = cnt_nx;
    end else begin : g_trail
      assign in_phase = cnt_nx >= duty_val;
      assign elapsed  = cnt_nx - duty_val;
    end
  endgenerate

  assign gate_open = !dt_on || (elapsed >= dt_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= in_phase && gate_open;
  end
endmodule

// File: rtl/pwm_dt_gen.sv
module pwm_dt_gen #(
  parameter int unsigned CNT_W = pwm_dt_pkg::DEF_CNT_W,
  parameter int unsigned DT_W  = pwm_dt_pkg::DEF_DT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] duty_val,
  input  logic [CNT_W-1:0] top_val,
  input  logic [DT_W-1:0]  dt_ticks,
  input  logic             dt_on,
  output logic             pwm_hi,
  output logic             pwm_lo,
  output logic             wrap_pulse
);
  localparam int unsigned N_CH = 2;

  logic [CNT_W-1:0] cnt_nx;
  logic [N_CH-1:0]  pwm_q;

  pwm_dt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .top_val (top_val),
    .cnt_nx  (cnt_nx),
    .wrap_q  (wrap_pulse)
  );

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    localparam pwm_dt_pkg::phase_e PH =
      (gi == 0) ? pwm_dt_pkg::PH_LEAD : pwm_dt_pkg::PH_TRAIL;
    pwm_dt_phase #(.CNT_W(CNT_W), .DT_W(DT_W), .PHASE(PH)) i_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_nx   (cnt_nx),
      .duty_val (duty_val),
      .dt_ticks (dt_ticks),
      .dt_on    (dt_on),
      .pwm_q    (pwm_q[gi])
    );
  end

  assign pwm_hi = pwm_q[0];
  assign pwm_lo = pwm_q[1];
endmodule

// File: rtl/pwm_dt_checker.sv
module pwm_dt_checker #(
  parameter int unsigned CNT_W = pwm_dt_pkg::DEF_CNT_W,
  parameter int unsigned DT_W  = pwm_dt_pkg::DEF_DT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] duty_val,
  input logic [DT_W-1:0]  dt_ticks,
  input logic             dt_on,
  input logic             pwm_hi,
  input logic             pwm_lo,
  input logic             wrap_pulse
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'b00;
    else        age <= {age[0], 1'b1};
  end

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi && pwm_lo));

  assert_inverse_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n || !age[0])
    $past(!dt_on) |-> (pwm_hi != pwm_lo));

  assert_zero_dt_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n || !age[0])
    $past(dt_on && dt_ticks == '0) |-> (pwm_hi != pwm_lo));

  assert_wrap_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n || !age[0])
    wrap_pulse |-> $past(cnt_tick));

  assert_hi_rise_gap_R5: assert property (@(posedge clk) disable iff (!rst_n || !age[1])
    ($rose(pwm_hi) && $past(dt_on && dt_ticks != '0) && $past(dt_on && dt_ticks != '0, 2)
     && $past(duty_val) == $past(duty_val, 2)) |-> !$past(pwm_lo));

  assert_lo_rise_gap_R6: assert property (@(posedge clk) disable iff (!rst_n || !age[1])
    ($rose(pwm_lo) && $past(dt_on && dt_ticks != '0) && $past(dt_on && dt_ticks != '0, 2)
     && $past(duty_val) == $past(duty_val, 2)) |-> !$past(pwm_hi));
endmodule

bind pwm_dt_gen pwm_dt_checker #(.CNT_W(CNT_W), .DT_W(DT_W)) i_pwm_dt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_tick   (cnt_tick),
  .duty_val   (duty_val),
  .dt_ticks   (dt_ticks),
  .dt_on      (dt_on),
  .pwm_hi     (pwm_hi),
  .pwm_lo     (pwm_lo),
  .wrap_pulse (wrap_pulse)
);

// File: tb/test_pwm_dt_gen.sv
`timescale 1ns/1ps
module test_pwm_dt_gen;
  localparam int CNT_W = 16;
  localparam int DT_W  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cnt_tick = 1'b0;
  logic [CNT_W-1:0] duty_val = '0;
  logic [CNT_W-1:0] top_val = '0;
  logic [DT_W-1:0]  dt_ticks = '0;
  logic             dt_on = 1'b0;
  logic             pwm_hi, pwm_lo, wrap_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int hi_seen, lo_seen, wraps;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dt_gen #(.CNT_W(CNT_W), .DT_W(DT_W)) i_pwm_dt_gen (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .duty_val(duty_val),
    .top_val(top_val), .dt_ticks(dt_ticks), .dt_on(dt_on),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .wrap_pulse(wrap_pulse));

  function automatic bit exp_hi(int c, int d, int t, bit en);
    return (c < d) && (!en || c >= t);
  endfunction

  function automatic bit exp_lo(int c, int d, int t, bit en);
    return (c >= d) && (!en || (c - d) >= t);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d count=%0d", tag, act, exp, m_cnt);
    end
  endtask

  // one clock: drive at negedge, compare at next negedge against the model
  task automatic step(bit tk, string tag);
    bit w;
    int eh, el;
    cnt_tick = tk;
    @(posedge clk);
    @(negedge clk);
    w = tk && (m_cnt >= int'(top_val));
    if (tk) m_cnt = w ? 0 : m_cnt + 1;
    eh = exp_hi(m_cnt, int'(duty_val), int'(dt_ticks), dt_on);
    el = exp_lo(m_cnt, int'(duty_val), int'(dt_ticks), dt_on);
    chk(pwm_hi === eh[0] && pwm_lo === el[0], tag, {pwm_hi, pwm_lo}, {eh[0], el[0]});
    chk(wrap_pulse === w, "R1 R2 wrap", wrap_pulse, w);
    chk(!(pwm_hi && pwm_lo), "R7 overlap", {pwm_hi, pwm_lo}, 0);
    if (pwm_hi) hi_seen++;
    if (pwm_lo) lo_seen++;
    if (wrap_pulse) wraps++;
  endtask

  task automatic cfg(int d, int t, int dt, bit en);
    duty_val = CNT_W'(d);
    top_val  = CNT_W'(t);
    dt_ticks = DT_W'(dt);
    dt_on    = en;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    cfg(10, 19, 3, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_hi === 0 && pwm_lo === 0 && wrap_pulse === 0, "R11 reset",
        {pwm_hi, pwm_lo, wrap_pulse}, 0);
    rst_n = 1'b1;

    // R1 R2: period is top+1 ticks
    cfg(4, 9, 0, 1'b0);
    wraps = 0;
    for (int i = 0; i < 40; i++) step(1'b1, "R3");
    chk(wraps == 4, "R1 wrap count", wraps, 4);

    // align to period start
    while (m_cnt != 0) step(1'b1, "R3");
    cfg(10, 19, 0, 1'b0);
    for (int i = 0; i < 60; i++) step(1'b1, "R3 R4");
    cfg(10, 19, 0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, "R8");
    cfg(10, 19, 3, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, "R5 R6");

    // R9: dead time longer than both phases
    cfg(10, 19, 15, 1'b1);
    step(1'b1, "R9");
    hi_seen = 0;
    lo_seen = 0;
    for (int i = 0; i < 40; i++) step(1'b1, "R9");
    chk(hi_seen == 0 && lo_seen == 0, "R9 no pulse", hi_seen + lo_seen, 0);

    // R10: no ticks, count holds
    cfg(10, 19, 2, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, "R10");
    for (int i = 0; i < 12; i++) step(1'b0, "R10");

    // seeded random
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
    end
    for (int blk = 0; blk < 40; blk++) begin
      int t, d, dt;
      bit en;
      t  = $urandom_range(0, 40);
      d  = $urandom_range(0, 45);
      dt = $urandom_range(0, 20);
      en = 1'($urandom_range(0, 1));
      cfg(d, t, dt, en);
      for (int i = 0; i < 100; i++)
        step($urandom_range(0, 3) != 0, en ? "R5 R6 R9" : "R3 R4");
    end

    done = 1;
    summary();
  end
endmodule